// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Mode Controller

This block is a synthesizable behavioural model of a byte-wide, ultraviolet-erasable one-time-programmable memory. It is meant to stand in for such a part in a system simulation. Its inputs are an active-low chip select, an active-low output enable, a flag that marks programming voltage on the output-enable pin, and a flag that marks high voltage on address line 9. From these it picks one of seven modes: standby, output-disabled, read, identifier, program, verify or program-inhibit.

The data bus leaves the block as an 8-bit value plus a drive-enable, and the surrounding logic builds the tri-state pad from them. A write follows the physics of the cell, so it can only clear bits. Each program strobe sampled on a rising clock edge ANDs the incoming byte into the stored byte. An input used only in simulation stands in for optical erasure and sets every byte back to all ones. The array depth and both identifier codes are parameters.

Top module: `otp_mem_ctrl`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `a9_hv`=0 (read mode), `dq_oe`=1 and `dq_out` equals the byte stored at `addr`, with no clock delay.
- R2: With `ce_n`=1, `dq_oe`=0 whatever the values of `oe_n`, `vpp_on` and `a9_hv`.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_on`=0, `dq_oe`=0.
- R4: With `vpp_on`=1, `ce_n`=0 and `oe_n`=1 (program mode), a rising clock edge with `prog_stb`=1 replaces the byte at `addr` by the old byte AND `din`.
- R5: Programming never turns a stored 0 bit into 1. Writing 8'hFF over a byte leaves that byte unchanged.
- R6: With `vpp_on`=1 and `ce_n`=1 (inhibit), `prog_stb` changes no byte, and `dq_oe`=0.
- R7: With `vpp_on`=1, `ce_n`=0 and `oe_n`=0 (verify), `dq_oe`=1 and `dq_out` is the stored byte at `addr`. `prog_stb` writes nothing in this mode.
- R8: In read conditions with `a9_hv`=1 (identifier mode), `dq_out` is `MFR_CODE` (default 8'h2A) when `addr[0]`=0 and `DEV_CODE` (default 8'h9E) when `addr[0]`=1. The array is not read and is not changed.
- R9: Both identifier bytes have odd parity across bits 7..0, with bit 7 as the parity bit. A parameter value with even parity stops elaboration.
- R10: A rising edge with `erase_all`=1 sets every byte to 8'hFF in that one cycle, and takes priority over a program strobe on the same edge.
- R11: Whenever `dq_oe`=0, `dq_out` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for array writes and erase |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_on | input | 1 | Programming voltage present on the output-enable pin |
| a9_hv | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| prog_stb | input | 1 | Program strobe, sampled on the rising clock edge |
| erase_all | input | 1 | Simulation-only erase of the whole array to 8'hFF |
| dq_out | output | 8 | Data value for the bus pads |
| dq_oe | output | 1 | Drive enable for the bus pads |

## Verification
On every cycle the assertions check the following: standby and inhibit keep the bus released, inhibit and verify raise no write, a write only clears bits and yields old AND new, erase leaves the addressed byte at all ones, verify returns the stored byte, and a driven identifier byte has odd parity. Some behaviour only the directed scenarios can show. These are the exact identifier values for each state of address bit 0, the fact that identifier and inhibit accesses leave untouched bytes intact, a second write that lands on an already-cleared byte, and erase winning over a program strobe on the same edge.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_OUTDIS  = 3'd1,
    MODE_READ    = 3'd2,
    MODE_IDENT   = 3'd3,
    MODE_PROGRAM = 3'd4,
    MODE_VERIFY  = 3'd5,
    MODE_INHIBIT = 3'd6
  } otp_mode_e;

  // True when a byte carries an odd number of ones.
  function automatic logic has_odd_parity(input logic [7:0] b);
    return ^b;
  endfunction

  // Cell physics: a write can only pull ones down to zero.
  function automatic logic [7:0] program_merge(input logic [7:0] stored,
                                               input logic [7:0] incoming);
    return stored & incoming;
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_on,
  input  logic      a9_hv,
  input  logic      prog_stb,
  output otp_mode_e mode,
  output logic      wr_en,
  output logic      drive_en,
  output logic      id_sel
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_on ? MODE_INHIBIT : MODE_STANDBY;
    end else if (vpp_on) begin
      mode = oe_n ? MODE_PROGRAM : MODE_VERIFY;
    end else if (oe_n) begin
      mode = MODE_OUTDIS;
    end else begin
      mode = a9_hv ? MODE_IDENT : MODE_READ;
    end
  end

  assign wr_en    = (mode == MODE_PROGRAM) && prog_stb;
  assign drive_en = (mode == MODE_READ) || (mode == MODE_IDENT) ||
                    (mode == MODE_VERIFY);
  assign id_sel   = (mode == MODE_IDENT);

endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              wr_en,
  input  logic              erase_all,
  output logic [7:0]        rd_word
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= 8'hFF;
      end
    end else if (wr_en) begin
      cells[addr] <= program_merge(cells[addr], din);
    end
  end

  assign rd_word = cells[addr];

endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux #(
  parameter logic [7:0] MFR_CODE = 8'h2A,
  parameter logic [7:0] DEV_CODE = 8'h9E
) (
  input  logic       drive_en,
  input  logic       id_sel,
  input  logic       sel_lsb,
  input  logic [7:0] array_word,
  output logic [7:0] dq_out,
  output logic       dq_oe
);

  logic [7:0] id_byte;

  assign id_byte = sel_lsb ? DEV_CODE : MFR_CODE;
  assign dq_oe   = drive_en;

  always_comb begin
    if (!drive_en) begin
      dq_out = 8'h00;
    end else if (id_sel) begin
      dq_out = id_byte;
    end else begin
      dq_out = array_word;
    end
  end

endmodule

// File: rtl/otp_mem_ctrl.sv
module otp_mem_ctrl
  import otp_pkg::*;
#(
  parameter int          DEPTH    = 256,
  parameter logic [7:0]  MFR_CODE = 8'h2A,
  parameter logic [7:0]  DEV_CODE = 8'h9E,
  localparam int         ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              prog_stb,
  input  logic              erase_all,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);

  // Identifier codes must carry odd parity (R9).
  if (!has_odd_parity(MFR_CODE)) begin : g_bad_mfr
    $error("MFR_CODE parameter has even parity");
  end
  if (!has_odd_parity(DEV_CODE)) begin : g_bad_dev
    $error("DEV_CODE parameter has even parity");
  end

  otp_mode_e  mode;
  logic       wr_en;
  logic       drive_en;
  logic       id_sel;
  logic [7:0] cur_word;

  otp_mode_decode u_decode (
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .vpp_on   (vpp_on),
    .a9_hv    (a9_hv),
    .prog_stb (prog_stb),
    .mode     (mode),
    .wr_en    (wr_en),
    .drive_en (drive_en),
    .id_sel   (id_sel)
  );

  otp_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk       (clk),
    .addr      (addr),
    .din       (din),
    .wr_en     (wr_en),
    .erase_all (erase_all),
    .rd_word   (cur_word)
  );

  otp_out_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
    .drive_en   (drive_en),
    .id_sel     (id_sel),
    .sel_lsb    (addr[0]),
    .array_word (cur_word),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

endmodule

// File: rtl/otp_mem_ctrl_chk.sv
module otp_mem_ctrl_chk
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_on,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        din,
  input logic              erase_all,
  input logic              wr_en,
  input otp_mode_e         mode,
  input logic [7:0]        cur_word,
  input logic [7:0]        dq_out,
  input logic              dq_oe
);

  // Array contents are defined only after the first erase.
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (erase_all) primed <= 1'b1;
  end

  AST_STANDBY_RELEASE: assert property (@(posedge clk)
    ce_n |-> (!dq_oe && dq_out == 8'h00)); // R2

  AST_OUTDIS_RELEASE: assert property (@(posedge clk)
    (!ce_n && oe_n && !vpp_on) |-> !dq_oe); // R3

  AST_INHIBIT_NO_WRITE: assert property (@(posedge clk)
    (vpp_on && ce_n) |-> !wr_en); // R6

  AST_VERIFY_NO_WRITE: assert property (@(posedge clk)
    (vpp_on && !ce_n && !oe_n) |-> !wr_en); // R7

  AST_VERIFY_DATA: assert property (@(posedge clk) disable iff (!primed)
    (mode == MODE_VERIFY) |-> (dq_oe && dq_out == cur_word)); // R7

  AST_WRITE_MERGE: assert property (@(posedge clk) disable iff (!primed)
    (wr_en && !erase_all) |=>
      (!$stable(addr) || cur_word == ($past(cur_word) & $past(din)))); // R4

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!primed)
    (wr_en && !erase_all) |=>
      (!$stable(addr) || (cur_word & ~$past(cur_word)) == 8'h00)); // R5

  AST_ERASE_ONES: assert property (@(posedge clk)
    erase_all |=> (cur_word == 8'hFF)); // R10

  AST_ID_PARITY: assert property (@(posedge clk)
    (mode == MODE_IDENT) |-> (dq_oe && has_odd_parity(dq_out))); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk)
    !dq_oe |-> (dq_out == 8'h00)); // R11

endmodule

bind otp_mem_ctrl otp_mem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .vpp_on    (vpp_on),
  .addr      (addr),
  .din       (din),
  .erase_all (erase_all),
  .wr_en     (wr_en),
  .mode      (mode),
  .cur_word  (cur_word),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe)
);

// File: tb/otp_mem_ctrl_tb.sv
module otp_mem_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int AW         = 8;
  localparam logic [7:0] MFR = 8'h2A;
  localparam logic [7:0] DEV = 8'h9E;

  logic          clk = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_on = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic          prog_stb = 1'b0, erase_all = 1'b0;
  logic [7:0]    dq_out;
  logic          dq_oe;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_mem_ctrl #(.DEPTH(DEPTH), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
    .clk(clk), .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on), .a9_hv(a9_hv),
    .addr(addr), .din(din), .prog_stb(prog_stb), .erase_all(erase_all),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [8:0] act,
                       input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic o, input logic v,
                      input logic a9, input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_on = v; a9_hv = a9; addr = a;
    #1;
  endtask

  // Read mode, compare {oe, data} at once.
  task automatic read_expect(input string req, input logic [AW-1:0] a,
                             input logic [7:0] exp);
    pins(1'b0, 1'b0, 1'b0, 1'b0, a);
    check(req, {dq_oe, dq_out}, {1'b1, exp});
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
    pins(1'b0, 1'b1, 1'b1, 1'b0, a);
    din = d; prog_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    prog_stb = 1'b0;
    ce_n = 1'b1; vpp_on = 1'b0;
  endtask

  task automatic erase_chip();
    @(negedge clk);
    erase_all = 1'b1;
    @(posedge clk);
    @(negedge clk);
    erase_all = 1'b0;
  endtask

  task automatic t_idle_state();
    pins(1'b1, 1'b1, 1'b0, 1'b0, 8'd0);
    check("R2 idle pins", {dq_oe, dq_out}, 9'h000);
  endtask

  task automatic t_erase();
    erase_chip();
    read_expect("R10 erase byte 0", 8'd0, 8'hFF);
    read_expect("R10 erase byte 255", 8'd255, 8'hFF);
    read_expect("R1 read erased 17", 8'd17, 8'hFF);
  endtask

  task automatic t_program();
    program_byte(8'd5, 8'hA5);
    read_expect("R4 program A5", 8'd5, 8'hA5);
    program_byte(8'd5, 8'h5A);
    read_expect("R5 A5 then 5A", 8'd5, 8'h00);
    program_byte(8'd7, 8'h3C);
    program_byte(8'd7, 8'hFF);
    read_expect("R5 FF over 3C", 8'd7, 8'h3C);
    program_byte(8'd8, 8'hF0);
    program_byte(8'd8, 8'h3F);
    read_expect("R4 F0 then 3F", 8'd8, 8'h30);
    read_expect("R1 neighbour untouched", 8'd6, 8'hFF);
  endtask

  task automatic t_standby();
    pins(1'b1, 1'b0, 1'b0, 1'b0, 8'd5);
    check("R2 standby oe low", {dq_oe, dq_out}, 9'h000);
    pins(1'b1, 1'b0, 1'b0, 1'b1, 8'd1);
    check("R2 standby with a9", {dq_oe, dq_out}, 9'h000);
    pins(1'b0, 1'b1, 1'b0, 1'b0, 8'd5);
    check("R3 output disabled", {dq_oe, dq_out}, 9'h000);
    check("R11 data zero when idle", {1'b0, dq_out}, 9'h000);
  endtask

  task automatic t_inhibit();
    pins(1'b1, 1'b1, 1'b1, 1'b0, 8'd10);
    din = 8'h00; prog_stb = 1'b1;
    #1;
    check("R6 inhibit bus released", {dq_oe, dq_out}, 9'h000);
    @(posedge clk);
    @(negedge clk);
    prog_stb = 1'b0;
    read_expect("R6 inhibit kept byte", 8'd10, 8'hFF);
  endtask

  task automatic t_verify();
    program_byte(8'd20, 8'h81);
    pins(1'b0, 1'b0, 1'b1, 1'b0, 8'd20);
    din = 8'h00; prog_stb = 1'b1;
    #1;
    check("R7 verify data", {dq_oe, dq_out}, {1'b1, 8'h81});
    @(posedge clk);
    @(negedge clk);
    prog_stb = 1'b0;
    #1;
    check("R7 verify after strobe", {dq_oe, dq_out}, {1'b1, 8'h81});
    read_expect("R7 no write in verify", 8'd20, 8'h81);
  endtask

  task automatic t_ident();
    pins(1'b0, 1'b0, 1'b0, 1'b1, 8'd0);
    check("R8 manufacturer byte", {dq_oe, dq_out}, {1'b1, MFR});
    check("R9 manufacturer parity", {8'h00, ^dq_out}, 9'h001);
    pins(1'b0, 1'b0, 1'b0, 1'b1, 8'd5);
    check("R8 device byte at odd addr", {dq_oe, dq_out}, {1'b1, DEV});
    check("R9 device parity", {8'h00, ^dq_out}, 9'h001);
    read_expect("R8 array intact", 8'd5, 8'h00);
  endtask

  task automatic t_erase_priority();
    pins(1'b0, 1'b1, 1'b1, 1'b0, 8'd30);
    din = 8'h00; prog_stb = 1'b1; erase_all = 1'b1;
    @(posedge clk);
    @(negedge clk);
    prog_stb = 1'b0; erase_all = 1'b0;
    ce_n = 1'b1; vpp_on = 1'b0;
    read_expect("R10 erase beats strobe", 8'd30, 8'hFF);
    read_expect("R10 erased programmed byte", 8'd20, 8'hFF);
  endtask

  initial begin
    fork
      begin
        t_idle_state();
        t_erase();
        t_program();
        t_standby();
        t_inhibit();
        t_verify();
        t_ident();
        t_erase_priority();
      end
      begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule